// File: doc/BRIEF.md
# Vector Step Query and Control Unit

This unit runs one vector-stepping instruction at a time against a small vector-loop state register. The register holds a source element index, a destination element index, a source sub-element index, a destination sub-element index, and two ordering-mode bits (pack and unpack). The unit splits the 32-bit instruction word into its destination-register, source-register, selector, step-enable and condition-record fields. It then does one of three things. It can return a loop index or one of four externally supplied shape offsets. It can rewrite the ordering-mode bits. Or it can ask a separate element-iterator block to advance the loop position once.

The result comes out of a register. It carries a one-cycle valid strobe, the destination register number, the source register number and an optional loop-end flag. An advance request is a level handshake. The unit raises `step_req` and holds `busy` until the iterator returns `step_done` with the next index values. The unit loads those values into its state and then issues the result. An instruction word presented while the unit is busy is dropped. The primary and extended opcode fields are not examined, because an upstream decoder has already routed the word here.

Top module: `vstep_unit`

## Requirements
- R1: After reset, every state output (`st_src`, `st_dst`, `st_ssub`, `st_dsub`, `st_pack`, `st_unpack`) is zero, and `busy`, `step_req`, `res_valid` and `res_loop_end` are low.
- R2: Fields are taken from the instruction word `insn` as follows:
  - the destination register from `insn[25:21]`, echoed on `res_rt`;
  - the source register from `insn[20:16]`, echoed on `res_ra`;
  - the selector from `insn[15:9]`;
  - the step-enable bit from `insn[6]`;
  - the condition-record bit from `insn[0]`.
- R3: A word with selector 0, step-enable 0 and condition-record 0 is a no-operation. It changes no state and produces no `res_valid` strobe.
- R4: Selectors 1, 2, 3 and 4 return `shape_off[0]`, `shape_off[1]`, `shape_off[2]` and `shape_off[3]` respectively, zero-extended. `res_valid` is high for exactly the cycle after the accepting clock edge.
- R5: Selectors 5, 6, 7 and 8 return, zero-extended, the source index, the destination index, the source sub-index and the destination sub-index as they stood before the instruction.
- R6: With step-enable 1, the selector sets the mode bits as follows:
  - selector 12 clears both pack and unpack;
  - selector 13 sets pack and clears unpack;
  - selector 14 sets unpack and clears pack.
  The result value for these selectors is zero.
- R7: With step-enable 0, no state output changes, whatever the selector, including selectors 12 to 14.
- R8: With step-enable 1 and selector 0, the unit behaves as follows:
  - `step_req` and `busy` go high from the cycle after acceptance and stay high until `step_done` is sampled high;
  - at that edge the four indices load `nxt_src`, `nxt_dst`, `nxt_ssub` and `nxt_dsub`, and the mode bits are kept;
  - in the next cycle `res_valid` is high with a result value of zero.
- R9: When condition-record is 1, `res_loop_end` is high with the result if either of these holds, evaluated on the state after the instruction:
  - the source index equals `cfg_vl`-1 and the source sub-index equals `cfg_subvl`;
  - the destination index equals `cfg_vl`-1 and the destination sub-index equals `cfg_subvl`.
  Otherwise, and whenever `res_valid` is low, `res_loop_end` is 0.
- R10: Selectors 9 to 11 and 15 to 127 return zero and change no state, whatever the step-enable bit.
- R11: An `insn_valid` seen while `busy` is high is ignored. It produces no result and no state change, even after the advance completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_valid | input | 1 | Instruction word present |
| insn | input | 32 | Instruction word |
| shape_off | input | NSHAPE x OFF_W | Current offsets of the four shape units |
| cfg_vl | input | STEP_W | Vector length |
| cfg_subvl | input | SUB_W | Sub-vector length minus one |
| busy | output | 1 | Waiting on the iterator; new words are dropped |
| step_req | output | 1 | Advance request to the iterator |
| step_done | input | 1 | Iterator has the next indices ready |
| nxt_src | input | STEP_W | Next source index from the iterator |
| nxt_dst | input | STEP_W | Next destination index from the iterator |
| nxt_ssub | input | SUB_W | Next source sub-index from the iterator |
| nxt_dsub | input | SUB_W | Next destination sub-index from the iterator |
| st_src | output | STEP_W | Current source index |
| st_dst | output | STEP_W | Current destination index |
| st_ssub | output | SUB_W | Current source sub-index |
| st_dsub | output | SUB_W | Current destination sub-index |
| st_pack | output | 1 | Pack ordering bit |
| st_unpack | output | 1 | Unpack ordering bit |
| res_valid | output | 1 | One-cycle result strobe |
| res_rt | output | 5 | Destination register of the result |
| res_ra | output | 5 | Source register field of the instruction |
| res_value | output | XLEN | Result value |
| res_loop_end | output | 1 | Loop-end flag, meaningful only when condition-record was set |

## Verification
The assertions assume the following about the inputs:
- the iterator raises `step_done` only while `step_req` is high;
- the iterator's next-index inputs are stable in the cycle they are taken;
- `shape_off` is stable across the accepting edge, so a returned offset can be compared one cycle later.

The stimulus pulses `step_done` only inside a wait window that the bench itself has observed through `step_req`, and changes the shape offsets and configuration only at falling edges before a new word. It deliberately presents words while the unit is busy, because dropping them is part of the contract rather than an input assumption.

// File: rtl/vstep_pkg.sv
package vstep_pkg;

    parameter int XLEN   = 64;
    parameter int STEP_W = 7;
    parameter int SUB_W  = 2;
    parameter int OFF_W  = 8;
    parameter int NSHAPE = 4;
    parameter int SEL_W  = 7;
    parameter int REG_W  = 5;

    localparam int SEL_SHAPE0 = 1;
    localparam int SEL_SRC    = 5;
    localparam int SEL_DST    = 6;
    localparam int SEL_SSUB   = 7;
    localparam int SEL_DSUB   = 8;
    localparam int SEL_MCLR   = 12;
    localparam int SEL_MPACK  = 13;
    localparam int SEL_MUNPK  = 14;

    typedef enum logic [1:0] {K_NOP, K_RESULT, K_STEP} kind_e;
    typedef enum logic [1:0] {M_KEEP, M_CLEAR, M_PACK, M_UNPACK} mode_e;

    typedef struct packed {
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] ra;
        logic [SEL_W-1:0] sel;
        logic             vf;
        logic             rc;
    } fields_t;

    typedef struct packed {
        kind_e            kind;
        mode_e            mode;
        logic             rc;
        logic [REG_W-1:0] rt;
        logic [REG_W-1:0] ra;
    } op_t;

    typedef struct packed {
        logic [STEP_W-1:0] src;
        logic [STEP_W-1:0] dst;
        logic [SUB_W-1:0]  ssub;
        logic [SUB_W-1:0]  dsub;
        logic              pack;
        logic              unpack;
    } vstate_t;

    // Field k counted from the most significant end sits at word bit 31-k.
    function automatic fields_t split_word(input logic [31:0] w);
        fields_t f;
        f.rt  = w[25:21];
        f.ra  = w[20:16];
        f.sel = w[15:9];
        f.vf  = w[6];
        f.rc  = w[0];
        return f;
    endfunction

    function automatic logic at_end(input vstate_t s,
                                    input logic [STEP_W-1:0] vl,
                                    input logic [SUB_W-1:0] subvl);
        logic [STEP_W-1:0] last;
        last = vl - STEP_W'(1);
        return ((s.src == last) && (s.ssub == subvl)) ||
               ((s.dst == last) && (s.dsub == subvl));
    endfunction

endpackage

// File: rtl/vstep_decode.sv
module vstep_decode
    import vstep_pkg::*;
(
    input  logic [31:0]      insn,
    output op_t              op,
    output logic [SEL_W-1:0] sel
);
    fields_t f;
    logic    unused_bits;

    assign f           = split_word(insn);
    assign sel         = f.sel;
    assign unused_bits = ^{insn[31:26], insn[8:7], insn[5:1]};

    always_comb begin
        op.rt   = f.rt;
        op.ra   = f.ra;
        op.rc   = f.rc;
        op.mode = M_KEEP;
        if (f.sel == '0 && !f.vf && !f.rc) begin
            op.kind = K_NOP;
        end else if (f.sel == '0 && f.vf) begin
            op.kind = K_STEP;
        end else begin
            op.kind = K_RESULT;
        end
        if (f.vf) begin
            case (f.sel)
                SEL_W'(SEL_MCLR):  op.mode = M_CLEAR;
                SEL_W'(SEL_MPACK): op.mode = M_PACK;
                SEL_W'(SEL_MUNPK): op.mode = M_UNPACK;
                default:           op.mode = M_KEEP;
            endcase
        end
    end
endmodule

// File: rtl/vstep_readmux.sv
module vstep_readmux
    import vstep_pkg::*;
(
    input  logic [SEL_W-1:0]             sel,
    input  logic [NSHAPE-1:0][OFF_W-1:0] shape_off,
    input  logic [STEP_W-1:0]            src,
    input  logic [STEP_W-1:0]            dst,
    input  logic [SUB_W-1:0]             ssub,
    input  logic [SUB_W-1:0]             dsub,
    output logic [XLEN-1:0]              value
);
    logic [NSHAPE-1:0]           hit;
    logic [NSHAPE-1:0][XLEN-1:0] wide;

    for (genvar k = 0; k < NSHAPE; k++) begin : g_shape
        assign hit[k]  = (sel == SEL_W'(SEL_SHAPE0 + k));
        assign wide[k] = XLEN'(shape_off[k]);
    end

    always_comb begin
        value = '0;
        for (int k = 0; k < NSHAPE; k++) begin
            if (hit[k]) value = wide[k];
        end
        case (sel)
            SEL_W'(SEL_SRC):  value = XLEN'(src);
            SEL_W'(SEL_DST):  value = XLEN'(dst);
            SEL_W'(SEL_SSUB): value = XLEN'(ssub);
            SEL_W'(SEL_DSUB): value = XLEN'(dsub);
            default: ;
        endcase
    end
endmodule

// File: rtl/vstep_state.sv
module vstep_state
    import vstep_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_we,
    input  mode_e             mode,
    input  logic              step_we,
    input  logic [STEP_W-1:0] nxt_src,
    input  logic [STEP_W-1:0] nxt_dst,
    input  logic [SUB_W-1:0]  nxt_ssub,
    input  logic [SUB_W-1:0]  nxt_dsub,
    output vstate_t           s
);
    always_ff @(posedge clk) begin
        if (rst) begin
            s <= '0;
        end else begin
            if (step_we) begin
                s.src  <= nxt_src;
                s.dst  <= nxt_dst;
                s.ssub <= nxt_ssub;
                s.dsub <= nxt_dsub;
            end
            if (mode_we) begin
                case (mode)
                    M_CLEAR:  begin s.pack <= 1'b0; s.unpack <= 1'b0; end
                    M_PACK:   begin s.pack <= 1'b1; s.unpack <= 1'b0; end
                    M_UNPACK: begin s.pack <= 1'b0; s.unpack <= 1'b1; end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/vstep_ctrl.sv
module vstep_ctrl
    import vstep_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             insn_valid,
    input  op_t              op,
    input  logic [XLEN-1:0]  rd_value,
    input  logic             end_now,
    input  logic             end_nxt,
    input  logic             step_done,
    output logic             busy,
    output logic             mode_we,
    output logic             step_we,
    output logic             res_valid,
    output logic [REG_W-1:0] res_rt,
    output logic [REG_W-1:0] res_ra,
    output logic [XLEN-1:0]  res_value,
    output logic             res_loop_end
);
    typedef enum logic {S_IDLE, S_WAIT} st_e;

    st_e              st;
    logic             accept;
    logic             pend_rc;
    logic [REG_W-1:0] pend_rt;
    logic [REG_W-1:0] pend_ra;

    assign busy    = (st == S_WAIT);
    assign accept  = insn_valid && !busy;
    assign mode_we = accept && (op.kind == K_RESULT) && (op.mode != M_KEEP);
    assign step_we = busy && step_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            st           <= S_IDLE;
            pend_rc      <= 1'b0;
            pend_rt      <= '0;
            pend_ra      <= '0;
            res_valid    <= 1'b0;
            res_rt       <= '0;
            res_ra       <= '0;
            res_value    <= '0;
            res_loop_end <= 1'b0;
        end else begin
            res_valid    <= 1'b0;
            res_loop_end <= 1'b0;
            case (st)
                S_IDLE: begin
                    if (accept && op.kind == K_RESULT) begin
                        res_valid    <= 1'b1;
                        res_value    <= rd_value;
                        res_rt       <= op.rt;
                        res_ra       <= op.ra;
                        res_loop_end <= op.rc && end_now;
                    end else if (accept && op.kind == K_STEP) begin
                        st      <= S_WAIT;
                        pend_rc <= op.rc;
                        pend_rt <= op.rt;
                        pend_ra <= op.ra;
                    end
                end
                S_WAIT: begin
                    if (step_done) begin
                        st           <= S_IDLE;
                        res_valid    <= 1'b1;
                        res_value    <= '0;
                        res_rt       <= pend_rt;
                        res_ra       <= pend_ra;
                        res_loop_end <= pend_rc && end_nxt;
                    end
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/vstep_unit.sv
module vstep_unit
    import vstep_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         insn_valid,
    input  logic [31:0]                  insn,
    input  logic [NSHAPE-1:0][OFF_W-1:0] shape_off,
    input  logic [STEP_W-1:0]            cfg_vl,
    input  logic [SUB_W-1:0]             cfg_subvl,
    output logic                         busy,
    output logic                         step_req,
    input  logic                         step_done,
    input  logic [STEP_W-1:0]            nxt_src,
    input  logic [STEP_W-1:0]            nxt_dst,
    input  logic [SUB_W-1:0]             nxt_ssub,
    input  logic [SUB_W-1:0]             nxt_dsub,
    output logic [STEP_W-1:0]            st_src,
    output logic [STEP_W-1:0]            st_dst,
    output logic [SUB_W-1:0]             st_ssub,
    output logic [SUB_W-1:0]             st_dsub,
    output logic                         st_pack,
    output logic                         st_unpack,
    output logic                         res_valid,
    output logic [REG_W-1:0]             res_rt,
    output logic [REG_W-1:0]             res_ra,
    output logic [XLEN-1:0]              res_value,
    output logic                         res_loop_end
);
    op_t              op;
    logic [SEL_W-1:0] sel;
    logic [XLEN-1:0]  rd_value;
    vstate_t          cur;
    vstate_t          nxt;
    logic             mode_we;
    logic             step_we;
    logic             end_now;
    logic             end_nxt;

    assign nxt     = '{src: nxt_src, dst: nxt_dst, ssub: nxt_ssub,
                       dsub: nxt_dsub, pack: cur.pack, unpack: cur.unpack};
    assign end_now = at_end(cur, cfg_vl, cfg_subvl);
    assign end_nxt = at_end(nxt, cfg_vl, cfg_subvl);

    vstep_decode u_dec (
        .insn (insn),
        .op   (op),
        .sel  (sel)
    );

    vstep_readmux u_mux (
        .sel       (sel),
        .shape_off (shape_off),
        .src       (cur.src),
        .dst       (cur.dst),
        .ssub      (cur.ssub),
        .dsub      (cur.dsub),
        .value     (rd_value)
    );

    vstep_state u_state (
        .clk      (clk),
        .rst      (rst),
        .mode_we  (mode_we),
        .mode     (op.mode),
        .step_we  (step_we),
        .nxt_src  (nxt_src),
        .nxt_dst  (nxt_dst),
        .nxt_ssub (nxt_ssub),
        .nxt_dsub (nxt_dsub),
        .s        (cur)
    );

    vstep_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .insn_valid   (insn_valid),
        .op           (op),
        .rd_value     (rd_value),
        .end_now      (end_now),
        .end_nxt      (end_nxt),
        .step_done    (step_done),
        .busy         (busy),
        .mode_we      (mode_we),
        .step_we      (step_we),
        .res_valid    (res_valid),
        .res_rt       (res_rt),
        .res_ra       (res_ra),
        .res_value    (res_value),
        .res_loop_end (res_loop_end)
    );

    assign step_req  = busy;
    assign st_src    = cur.src;
    assign st_dst    = cur.dst;
    assign st_ssub   = cur.ssub;
    assign st_dsub   = cur.dsub;
    assign st_pack   = cur.pack;
    assign st_unpack = cur.unpack;
endmodule

// File: rtl/vstep_unit_chk.sv
module vstep_unit_chk
    import vstep_pkg::*;
(
    input logic                         clk,
    input logic                         rst,
    input logic                         insn_valid,
    input logic [31:0]                  insn,
    input logic [NSHAPE-1:0][OFF_W-1:0] shape_off,
    input logic                         busy,
    input logic                         step_req,
    input logic                         step_done,
    input logic [STEP_W-1:0]            st_src,
    input logic [STEP_W-1:0]            st_dst,
    input logic [SUB_W-1:0]             st_ssub,
    input logic [SUB_W-1:0]             st_dsub,
    input logic                         st_pack,
    input logic                         st_unpack,
    input logic                         res_valid,
    input logic [XLEN-1:0]              res_value,
    input logic                         res_loop_end
);
    logic       acc;
    logic [6:0] w_sel;
    logic       w_vf;
    logic       w_rc;

    assign acc   = insn_valid && !busy;
    assign w_sel = insn[15:9];
    assign w_vf  = insn[6];
    assign w_rc  = insn[0];

    a_r1_clean_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !busy && !res_valid && st_src == '0 && st_dst == '0 &&
                       st_ssub == '0 && st_dsub == '0 && !st_pack && !st_unpack);

    a_r3_nop_silent: assert property (@(posedge clk) disable iff (rst)
        acc && w_sel == 7'd0 && !w_vf && !w_rc |=>
            !res_valid && $stable(st_src) && $stable(st_dst) &&
            $stable(st_pack) && $stable(st_unpack));

    a_r4_shape_read: assert property (@(posedge clk) disable iff (rst)
        acc && w_sel == 7'd1 |=> res_valid && res_value == XLEN'($past(shape_off[0])));

    a_r6_pack_set: assert property (@(posedge clk) disable iff (rst)
        acc && w_vf && w_sel == 7'd13 |=> st_pack && !st_unpack);

    a_r7_enquiry_stable: assert property (@(posedge clk) disable iff (rst)
        acc && !w_vf |=> $stable(st_src) && $stable(st_dst) && $stable(st_ssub) &&
                         $stable(st_dsub) && $stable(st_pack) && $stable(st_unpack));

    a_r8_req_held: assert property (@(posedge clk) disable iff (rst)
        step_req && !step_done |=> step_req && $stable(st_src) && $stable(st_dst));

    a_r9_flag_with_result: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> !res_loop_end);

    a_r11_quiet_while_busy: assert property (@(posedge clk) disable iff (rst)
        busy && !step_done |=> !res_valid && $stable(st_pack) && $stable(st_unpack));
endmodule

bind vstep_unit vstep_unit_chk chk_i (.*);

// File: tb/vstep_unit_tb.sv
module vstep_unit_tb_top;
    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            insn_valid = 1'b0;
    logic [31:0]     insn = '0;
    logic [3:0][7:0] shape_off = '0;
    logic [6:0]      cfg_vl = 7'd8;
    logic [1:0]      cfg_subvl = 2'd0;
    logic            busy, step_req;
    logic            step_done = 1'b0;
    logic [6:0]      nxt_src = '0, nxt_dst = '0;
    logic [1:0]      nxt_ssub = '0, nxt_dsub = '0;
    logic [6:0]      st_src, st_dst;
    logic [1:0]      st_ssub, st_dsub;
    logic            st_pack, st_unpack;
    logic            res_valid, res_loop_end;
    logic [4:0]      res_rt, res_ra;
    logic [63:0]     res_value;

    int checks = 0;
    int errors = 0;

    logic [6:0] m_src = '0, m_dst = '0;
    logic [1:0] m_ssub = '0, m_dsub = '0;
    logic       m_pack = 1'b0, m_unpack = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vstep_unit dut_i (.*);

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [6:0] sel, input logic vf,
                                       input logic rc, input logic [4:0] rt,
                                       input logic [4:0] ra);
        return {6'd22, rt, ra, sel, 2'b00, vf, 5'd19, rc};
    endfunction

    function automatic logic [63:0] model_state();
        return 64'({m_src, m_dst, m_ssub, m_dsub, m_pack, m_unpack});
    endfunction

    function automatic logic [63:0] dut_state();
        return 64'({st_src, st_dst, st_ssub, st_dsub, st_pack, st_unpack});
    endfunction

    function automatic logic model_end();
        logic [6:0] last;
        last = cfg_vl - 7'd1;
        return ((m_src == last) && (m_ssub == cfg_subvl)) ||
               ((m_dst == last) && (m_dsub == cfg_subvl));
    endfunction

    function automatic logic [63:0] exp_value(input logic [6:0] sel);
        case (sel)
            7'd1, 7'd2, 7'd3, 7'd4: return 64'(shape_off[sel-7'd1]);
            7'd5: return 64'(m_src);
            7'd6: return 64'(m_dst);
            7'd7: return 64'(m_ssub);
            7'd8: return 64'(m_dsub);
            default: return 64'd0;
        endcase
    endfunction

    function automatic string val_tag(input logic [6:0] sel);
        if (sel >= 7'd1 && sel <= 7'd4) return "R4";
        if (sel >= 7'd5 && sel <= 7'd8) return "R5";
        if (sel >= 7'd12 && sel <= 7'd14) return "R6";
        return "R10";
    endfunction

    // One instruction: accept edge, optional iterator wait, then checks.
    task automatic run(input logic [6:0] sel, input logic vf, input logic rc,
                       input int wait_cyc, input bit intrude,
                       input logic [6:0] ns, input logic [6:0] nd,
                       input logic [1:0] nss, input logic [1:0] nds);
        logic [4:0]  rt, ra;
        logic [63:0] ev;
        rt = 5'($urandom);
        ra = 5'($urandom);
        @(negedge clk);
        insn = mk(sel, vf, rc, rt, ra);
        insn_valid = 1'b1;
        @(negedge clk);
        insn_valid = 1'b0;
        if (sel == 7'd0 && !vf && !rc) begin
            chk("R3 no strobe", 64'(res_valid), 64'd0);
            chk("R3 state", dut_state(), model_state());
        end else if (sel == 7'd0 && vf) begin
            chk("R8 request", 64'({step_req, busy, res_valid}), 64'b110);
            for (int i = 0; i < wait_cyc; i++) begin
                if (intrude) begin
                    insn = mk(7'd13, 1'b1, 1'b1, 5'd3, 5'd4);
                    insn_valid = 1'b1;
                end
                @(negedge clk);
                chk("R8 hold", 64'({step_req, res_valid}), 64'b10);
            end
            nxt_src = ns; nxt_dst = nd; nxt_ssub = nss; nxt_dsub = nds;
            step_done = 1'b1;
            @(negedge clk);
            step_done = 1'b0;
            insn_valid = 1'b0;
            m_src = ns; m_dst = nd; m_ssub = nss; m_dsub = nds;
            chk("R8 result", {res_valid, busy, res_value[61:0]}, {2'b10, 62'd0});
            chk("R2 rt/ra", 64'({res_rt, res_ra}), 64'({rt, ra}));
            chk("R9 flag", 64'(res_loop_end), 64'(rc && model_end()));
            chk("R8 state", dut_state(), model_state());
            if (intrude) begin
                @(negedge clk);
                chk("R11 ignored", 64'({res_valid, st_pack}), 64'({1'b0, m_pack}));
            end
        end else begin
            ev = exp_value(sel);
            chk("R4 strobe", 64'(res_valid), 64'd1);
            chk(val_tag(sel), res_value, ev);
            chk("R2 rt/ra", 64'({res_rt, res_ra}), 64'({rt, ra}));
            chk("R9 flag", 64'(res_loop_end), 64'(rc && model_end()));
            if (vf) begin
                case (sel)
                    7'd12: begin m_pack = 1'b0; m_unpack = 1'b0; end
                    7'd13: begin m_pack = 1'b1; m_unpack = 1'b0; end
                    7'd14: begin m_pack = 1'b0; m_unpack = 1'b1; end
                    default: ;
                endcase
                chk((sel >= 7'd12 && sel <= 7'd14) ? "R6 state" : "R10 state",
                    dut_state(), model_state());
            end else begin
                chk("R7 state", dut_state(), model_state());
            end
            @(negedge clk);
            chk("R4 one-cycle strobe", 64'({res_valid, res_loop_end}), 64'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 state", dut_state(), 64'd0);
        chk("R1 flags", 64'({busy, step_req, res_valid, res_loop_end}), 64'd0);

        shape_off = {8'hd4, 8'hc3, 8'hb2, 8'ha1};
        run(7'd0, 1'b0, 1'b0, 0, 0, 0, 0, 0, 0);
        for (int s = 1; s <= 4; s++) run(7'(s), 1'b0, 1'b0, 0, 0, 0, 0, 0, 0);
        run(7'd13, 1'b1, 1'b0, 0, 0, 0, 0, 0, 0);
        run(7'd14, 1'b0, 1'b0, 0, 0, 0, 0, 0, 0);
        run(7'd14, 1'b1, 1'b0, 0, 0, 0, 0, 0, 0);
        run(7'd12, 1'b1, 1'b0, 0, 0, 0, 0, 0, 0);
        run(7'd0, 1'b1, 1'b0, 3, 1, 7'd2, 7'd5, 2'd1, 2'd3);
        for (int s = 5; s <= 8; s++) run(7'(s), 1'b1, 1'b1, 0, 0, 0, 0, 0, 0);
        cfg_vl = 7'd4; cfg_subvl = 2'd1;
        run(7'd0, 1'b1, 1'b1, 0, 0, 7'd3, 7'd0, 2'd1, 2'd0);
        run(7'd0, 1'b1, 1'b1, 1, 0, 7'd1, 7'd3, 2'd0, 2'd1);
        run(7'd0, 1'b1, 1'b0, 0, 0, 7'd3, 7'd3, 2'd1, 2'd1);
        run(7'd0, 1'b0, 1'b1, 0, 0, 0, 0, 0, 0);
        run(7'd9, 1'b1, 1'b1, 0, 0, 0, 0, 0, 0);
        run(7'd127, 1'b1, 1'b0, 0, 0, 0, 0, 0, 0);
        run(7'd15, 1'b0, 1'b1, 0, 0, 0, 0, 0, 0);

        for (int n = 0; n < 400; n++) begin
            logic [6:0] sel, ns, nd;
            logic [1:0] nss, nds;
            @(negedge clk);
            shape_off = 32'($urandom);
            cfg_vl = 7'(1 + ($urandom % 64));
            cfg_subvl = 2'($urandom);
            sel = ($urandom % 8 == 0) ? 7'($urandom) : 7'($urandom % 16);
            ns = 7'($urandom % cfg_vl);
            nd = 7'($urandom % cfg_vl);
            nss = 2'($urandom);
            nds = 2'($urandom);
            if ($urandom % 3 == 0) begin ns = cfg_vl - 7'd1; nss = cfg_subvl; end
            if ($urandom % 5 == 0) begin nd = cfg_vl - 7'd1; nds = cfg_subvl; end
            run(sel, 1'($urandom), 1'($urandom), int'($urandom % 4),
                bit'($urandom % 4 == 0), ns, nd, nss, nds);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule